// File: doc/BRIEF.md
# Universal Bidirectional Bus Register Transceiver

This block joins two 18-bit ports, A and B, and carries data in both directions at once. Each direction has one storage register with three behaviours, picked by a pass-control and a strobe input. With pass high the register follows the far port, so the path is transparent. With pass low it keeps its contents while the strobe stays at either level. With pass low, a high-to-low strobe transition loads the far port's value. The B port's drivers are enabled by an active-high input, and the A port's drivers by an active-low input.

Each pad is split into a data-in vector, a data-out vector and a per-bit output-enable vector, so that a wrapper one level up can build the bidirectional pins. All pins are sampled into a fast system clock through a two-stage synchroniser. Strobe edges are found in that clock domain, so the strobe inputs need not be clocks. Data is carried through the same synchroniser as the controls, which keeps each data sample lined up with the control sample taken at the same time.

Top module: `bus_xcvr_univ`

## Requirements
- R1: While a direction's pass input is high, its output takes the far port's input value three system-clock edges after the change at the pins.
- R2: While pass is low and the strobe stays steady (high or low), the output keeps its stored value whatever the far port's input does.
- R3: While pass is low, a high-to-low strobe transition loads the far port's input into the storage register.
- R4: A low-to-high strobe transition with pass low leaves the stored value unchanged.
- R5: If pass falls while the strobe is low, and the strobe then stays low, the output keeps the input value that was present just before pass fell.
- R6: The B-port enable `b_drive` is active high: when it is 1, all 18 bits of `b_oe` are 1; when it is 0, all bits of `b_oe` are 0 (high impedance).
- R7: The A-port enable `a_drive_n` is active low: when it is 0, all bits of `a_oe` are 1; when it is 1, all bits of `a_oe` are 0.
- R8: The storage registers load and hold in the same way whether or not that port's outputs are enabled.
- R9: The B-to-A path follows R1 to R5, using `b2a_pass` and `b2a_strobe`, reads the B port and drives the A port.
- R10: A synchronous active-high reset clears both storage registers and both output-enable vectors on the next system-clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast system clock |
| rst | input | 1 | Synchronous reset, active high |
| a_in | input | 18 | Resolved value seen on the A pads |
| a_out | output | 18 | Value driven onto the A pads |
| a_oe | output | 18 | Per-bit drive enable of the A pads |
| b_in | input | 18 | Resolved value seen on the B pads |
| b_out | output | 18 | Value driven onto the B pads |
| b_oe | output | 18 | Per-bit drive enable of the B pads |
| a2b_pass | input | 1 | A-to-B pass control: high is transparent, low is storage |
| a2b_strobe | input | 1 | A-to-B strobe; its falling edge loads the register |
| b2a_pass | input | 1 | B-to-A pass control |
| b2a_strobe | input | 1 | B-to-A strobe |
| b_drive | input | 1 | B-port output enable, active high |
| a_drive_n | input | 1 | A-port output enable, active low |

## Verification
The assertions assume that every pin holds each level long enough for the synchroniser to sample it. Pulses shorter than a system-clock period may be lost. The assertions also assume that no port feeds its own stored value back through a transparent path. The stimulus changes one pin at a time and holds it for eight system clocks. The A-port drivers stay disabled whenever the A-to-B path is transparent, so the resolved pad values are always well defined.

// File: rtl/bxr_pkg.sv
package bxr_pkg;
    localparam int BUS_W       = 18;
    localparam int SYNC_STAGES = 2;

    typedef struct packed {
        logic pass;
        logic strobe;
    } lane_ctl_t;

    function automatic logic strobe_fell(input logic prev, input logic cur);
        return prev && !cur;
    endfunction
endpackage

// File: rtl/bxr_sync.sv
module bxr_sync #(
    parameter int W       = 1,
    parameter int STAGES  = 2,
    parameter bit RST_ONE = 1'b0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    localparam logic [W-1:0] RST_VAL = {W{RST_ONE}};

    logic [W-1:0] stage_q [STAGES];

    generate
        for (genvar g = 0; g < STAGES; g++) begin : g_stage
            always_ff @(posedge clk) begin
                if (rst)
                    stage_q[g] <= RST_VAL;
                else if (g == 0)
                    stage_q[g] <= din;
                else
                    stage_q[g] <= stage_q[(g == 0) ? 0 : g-1];
            end
        end
    endgenerate

    assign dout = stage_q[STAGES-1];
endmodule

// File: rtl/bxr_lane.sv
module bxr_lane
    import bxr_pkg::*;
#(
    parameter int W = BUS_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    input  lane_ctl_t    ctl,
    output logic [W-1:0] q
);
    logic strobe_prev;
    logic load;

    assign load = ctl.pass || strobe_fell(strobe_prev, ctl.strobe);

    always_ff @(posedge clk) begin
        if (rst) begin
            q           <= '0;
            strobe_prev <= 1'b0;
        end else begin
            strobe_prev <= ctl.strobe;
            if (load)
                q <= d;
        end
    end

    // R1
    pass_follow_chk: assert property (@(posedge clk) disable iff (rst)
        ctl.pass |=> (q == $past(d)));

    // R3
    fall_capture_chk: assert property (@(posedge clk) disable iff (rst)
        (!ctl.pass && strobe_prev && !ctl.strobe) |=> (q == $past(d)));

    // R2
    steady_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!ctl.pass && !(strobe_prev && !ctl.strobe)) |=> $stable(q));
endmodule

// File: rtl/bus_xcvr_univ.sv
module bus_xcvr_univ
    import bxr_pkg::*;
#(
    parameter int W      = BUS_W,
    parameter int STAGES = SYNC_STAGES
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] a_in,
    output logic [W-1:0] a_out,
    output logic [W-1:0] a_oe,
    input  logic [W-1:0] b_in,
    output logic [W-1:0] b_out,
    output logic [W-1:0] b_oe,
    input  logic         a2b_pass,
    input  logic         a2b_strobe,
    input  logic         b2a_pass,
    input  logic         b2a_strobe,
    input  logic         b_drive,
    input  logic         a_drive_n
);
    localparam int SYNC_W = 2*W + 5;

    logic [SYNC_W-1:0] raw_bus, sync_bus;
    logic [W-1:0]      a_s, b_s;
    lane_ctl_t         a2b_ctl, b2a_ctl;
    logic              b_drive_s, a_drive_n_s;

    assign raw_bus = {a_in, b_in, a2b_pass, a2b_strobe, b2a_pass, b2a_strobe, b_drive};

    bxr_sync #(.W(SYNC_W), .STAGES(STAGES), .RST_ONE(1'b0)) i_sync_main (
        .clk (clk),
        .rst (rst),
        .din (raw_bus),
        .dout(sync_bus)
    );

    bxr_sync #(.W(1), .STAGES(STAGES), .RST_ONE(1'b1)) i_sync_aen (
        .clk (clk),
        .rst (rst),
        .din (a_drive_n),
        .dout(a_drive_n_s)
    );

    assign {a_s, b_s, a2b_ctl, b2a_ctl, b_drive_s} = sync_bus;

    bxr_lane #(.W(W)) i_lane_a2b (
        .clk(clk),
        .rst(rst),
        .d  (a_s),
        .ctl(a2b_ctl),
        .q  (b_out)
    );

    bxr_lane #(.W(W)) i_lane_b2a (
        .clk(clk),
        .rst(rst),
        .d  (b_s),
        .ctl(b2a_ctl),
        .q  (a_out)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            b_oe <= '0;
            a_oe <= '0;
        end else begin
            b_oe <= {W{b_drive_s}};
            a_oe <= {W{~a_drive_n_s}};
        end
    end

    // R10
    reset_hiz_chk: assert property (@(posedge clk)
        rst |=> (a_oe == '0 && b_oe == '0 && a_out == '0 && b_out == '0));

    // R6
    b_enable_pol_chk: assert property (@(posedge clk) disable iff (rst)
        (b_drive_s && !$past(rst)) |=> (b_oe == '1));

    // R7
    a_enable_pol_chk: assert property (@(posedge clk) disable iff (rst)
        (a_drive_n_s && !$past(rst)) |=> (a_oe == '0));
endmodule

// File: tb/test_bus_xcvr_univ.sv
module test_bus_xcvr_univ;
    localparam int W        = 18;
    localparam int CLK_HALF = 5;
    localparam int SETTLE   = 8;
    localparam int WD_LIMIT = 150000;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [W-1:0] ext_a = '0, ext_b = '0;
    logic [W-1:0] a_in, b_in, a_out, b_out, a_oe, b_oe;
    logic         ab_pass = 0, ab_strb = 0, ba_pass = 0, ba_strb = 0;
    logic         b_en = 0, a_en_n = 1;

    int n_cmp = 0;
    int n_bad = 0;
    int cyc   = 0;
    bit done  = 0;

    logic [W-1:0] exp_ab = '0, exp_ba = '0;

    // Bus model: an enabled DUT driver wins over the external driver.
    assign a_in = (a_oe & a_out) | (~a_oe & ext_a);
    assign b_in = (b_oe & b_out) | (~b_oe & ext_b);

    always #CLK_HALF clk = ~clk;

    bus_xcvr_univ #(.W(W)) i_bus_xcvr_univ (
        .clk(clk), .rst(rst),
        .a_in(a_in), .a_out(a_out), .a_oe(a_oe),
        .b_in(b_in), .b_out(b_out), .b_oe(b_oe),
        .a2b_pass(ab_pass), .a2b_strobe(ab_strb),
        .b2a_pass(ba_pass), .b2a_strobe(ba_strb),
        .b_drive(b_en), .a_drive_n(a_en_n)
    );

    function automatic logic [W-1:0] nxt(input logic [W-1:0] cur, input logic pass,
                                         input logic old_s, input logic new_s,
                                         input logic [W-1:0] d);
        if (pass) return d;
        if (old_s && !new_s) return d;
        return cur;
    endfunction

    task automatic cmp(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic settle();
        repeat (SETTLE) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic check_all(input string tag);
        cmp({tag, " b_out"}, b_out, exp_ab);
        cmp({tag, " a_out"}, a_out, exp_ba);
        cmp({tag, " b_oe"},  b_oe,  b_en ? '1 : '0);
        cmp({tag, " a_oe"},  a_oe,  a_en_n ? '0 : '1);
    endtask

    // which: 0 ext_a, 1 ext_b, 2 ab_pass, 3 ab_strb, 4 ba_pass, 5 ba_strb, 6 b_en, 7 a_en_n
    task automatic apply(input int which, input logic [W-1:0] v, input string tag);
        logic o_ab, o_ba;
        logic [W-1:0] pad_a, pad_b;
        o_ab = ab_strb;
        o_ba = ba_strb;
        case (which)
            0: ext_a   = v;
            1: ext_b   = v;
            2: ab_pass = v[0];
            3: ab_strb = v[0];
            4: ba_pass = v[0];
            5: ba_strb = v[0];
            6: b_en    = v[0];
            default: a_en_n = v[0];
        endcase
        pad_a  = a_en_n ? ext_a : exp_ba;
        exp_ab = nxt(exp_ab, ab_pass, o_ab, ab_strb, pad_a);
        pad_b  = b_en ? exp_ab : ext_b;
        exp_ba = nxt(exp_ba, ba_pass, o_ba, ba_strb, pad_b);
        settle();
        check_all(tag);
    endtask

    initial begin
        @(posedge clk);
        while (!done) begin
            @(posedge clk);
            cyc++;
            if (cyc > WD_LIMIT) begin
                n_bad++;
                $display("FAIL watchdog: actual %0d cycles expected < %0d", cyc, WD_LIMIT);
                $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
                $finish;
            end
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R10 reset state
        check_all("R10 reset");

        // R1 transparent A-to-B, with a latency check at edge 3
        apply(2, 1, "R1 pass on");
        ext_a = 18'h2A5C3;
        repeat (2) @(posedge clk);
        @(negedge clk);
        cmp("R1 before latency", b_out, '0);
        @(posedge clk);
        @(negedge clk);
        cmp("R1 at latency", b_out, 18'h2A5C3);
        exp_ab = 18'h2A5C3;
        apply(0, 18'h15A3C, "R1 follow");

        // R5 pass falls with strobe low, then data changes
        apply(2, 0, "R5 pass falls");
        apply(0, 18'h3FFFF, "R5 hold low strobe");
        cmp("R5 value", b_out, 18'h15A3C);

        // R4 rising strobe ignored, R2 hold with strobe high
        apply(3, 1, "R4 rising edge");
        cmp("R4 value", b_out, 18'h15A3C);
        apply(0, 18'h0F0F0, "R2 hold high strobe");
        cmp("R2 value", b_out, 18'h15A3C);

        // R3 falling strobe loads
        apply(3, 0, "R3 falling edge");
        cmp("R3 value", b_out, 18'h0F0F0);

        // R6 B enable polarity
        apply(6, 1, "R6 enable on");
        apply(6, 0, "R6 enable off");

        // R8 load while disabled, then observe by enabling
        apply(0, 18'h1234B, "R8 data");
        apply(3, 1, "R8 rise");
        apply(3, 0, "R8 fall disabled");
        apply(6, 1, "R8 enable view");
        apply(6, 0, "R8 disable");

        // R9 B-to-A path
        apply(1, 18'h0BEEF, "R9 data");
        apply(4, 1, "R9 pass on");
        apply(4, 0, "R9 pass falls");
        apply(1, 18'h3C3C3, "R9 hold");
        apply(5, 1, "R9 rise");
        apply(5, 0, "R9 fall");
        cmp("R9 value", a_out, 18'h3C3C3);

        // R7 A enable polarity (A-to-B pass held low)
        apply(7, 0, "R7 enable on");
        apply(7, 1, "R7 enable off");

        // R10 reset mid-run
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        exp_ab = '0;
        exp_ba = '0;
        cmp("R10 mid b_out", b_out, '0);
        cmp("R10 mid a_out", a_out, '0);
        settle();
        check_all("R10 after");

        // Random mix; A drivers stay disabled (R1 R2 R3 R4 R9)
        for (int i = 0; i < 300; i++) begin
            int w;
            logic [W-1:0] v;
            w = int'($urandom % 7);
            v = (w < 2) ? W'($urandom) : W'($urandom % 2);
            apply(w, v, "R2 random");
        end

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule